// File: doc/BRIEF.md
# UART Status Flag Register with Handshake Clearing

This block keeps the eight status flags of a UART whose transmitter and receiver sit behind FIFOs. Two flags follow the transmit side: one tracks transmit FIFO occupancy against a programmable watermark, and one shows that transmission has completed. Six flags follow the receive side: one tracks receive FIFO level, and five latch one-cycle event pulses from the receiver (line idle, overrun, noise, framing error, parity error). Level-type flags set in every cycle their condition holds. Event flags set on the pulse. All flags stay set until they are cleared.

Software clears a flag in two steps. It reads the status register while the flag is high, which arms that flag. It then makes the matching data-register access: a write for the two transmit flags, a read for the six receive flags. Any number of unrelated bus accesses may fall between the two steps. A flag routed to DMA is cleared by its DMA-done strobe instead. A set condition present in the clearing cycle keeps the flag high, so no event is lost.

Each flag drives either the shared interrupt line or its own DMA request line. The block also passes data-register reads on as receive FIFO pops and data-register writes on as transmit FIFO pushes.

Top module: `uart_status_flags`

## Requirements
- R1: After reset the status byte is 0xC0, `irq_o` is 0 and `dma_req_o` is 0.
- R2: Bit 7 (transmit-empty) sets in every cycle where `tx_count_i` <= `tx_water_i`. `tx_count_i` excludes any word in the shifter.
- R3: Bit 6 (transmit-complete) sets in every cycle where `tx_count_i` is 0 and `tx_busy_i` is 0.
- R4: Bit 5 (receive-full) sets while `rx_count_i` is nonzero and >= `rx_water_i`. Bits 4, 3, 2, 1, 0 set on pulses of `rx_idle_i`, `rx_overrun_i`, `rx_noise_i`, `rx_frame_err_i` and `rx_parity_err_i`.
- R5: A status read (address `STAT_ADDR`, `bus_write_i`=0) that sees a flag high arms it. A later data write (address `DATA_ADDR`) clears armed bits 7 and 6. A later data read clears armed bits 5 to 0. Unrelated accesses in between do not disarm.
- R6: A flag is not cleared by a data access of the wrong kind, by a data access with no prior status read, or by a status read taken while the flag was low.
- R7: If a flag's set condition holds in the cycle it is cleared, the flag stays high.
- R8: When `dma_sel_i[k]` is 1, a pulse on `dma_done_i[k]` clears flag k without a status read and also disarms it. When `dma_sel_i[k]` is 0, the pulse has no effect.
- R9: `irq_o` is the OR of the flags k that have `irq_en_i[k]`=1 and `dma_sel_i[k]`=0. `dma_req_o[k]` is flag k AND `irq_en_i[k]` AND `dma_sel_i[k]`.
- R10: Every data read drives `rx_pop_o` in the same cycle, even when the receive FIFO is empty. Every data write drives `tx_push_o`. A `rx_flush_i` pulse disarms bits 5 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| tx_count_i | input | CNT_W | Words in the transmit FIFO, excluding the shifter |
| tx_water_i | input | CNT_W | Transmit watermark |
| tx_busy_i | input | 1 | Transmit shifter active |
| rx_count_i | input | CNT_W | Words in the receive FIFO |
| rx_water_i | input | CNT_W | Receive watermark |
| rx_idle_i | input | 1 | Idle-line pulse |
| rx_overrun_i | input | 1 | Overrun pulse |
| rx_noise_i | input | 1 | Noise pulse |
| rx_frame_err_i | input | 1 | Framing error pulse |
| rx_parity_err_i | input | 1 | Parity error pulse |
| rx_flush_i | input | 1 | Receive FIFO flush pulse |
| dma_sel_i | input | 8 | Per-flag routing to DMA |
| dma_done_i | input | 8 | Per-flag DMA completion strobes |
| irq_en_i | input | 8 | Per-flag request enable |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 8 | Per-flag DMA requests |
| rx_pop_o | output | 1 | Receive FIFO pop |
| tx_push_o | output | 1 | Transmit FIFO push |

## Verification
The assertions assume at most one bus access per cycle. They assume the receiver pulses last one cycle, and that `tx_count_i` and `tx_water_i` change only between clock edges. The stimulus drives every input half a cycle away from the sampling edge and issues one access per operation. It holds the FIFO counts steady across each handshake, except where a test is meant to remove a condition before the second step. DMA strobes are raised only on flags whose routing the test has chosen deliberately.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int NFLAG = 8;
  localparam int B_TXE   = 7;
  localparam int B_TXC   = 6;
  localparam int B_RXF   = 5;
  localparam int B_IDLE  = 4;
  localparam int B_OVR   = 3;
  localparam int B_NOISE = 2;
  localparam int B_FRM   = 1;
  localparam int B_PAR   = 0;
  // bits cleared by data write; the rest by data read
  localparam logic [NFLAG-1:0] TX_MASK = 8'hC0;
  localparam logic [NFLAG-1:0] RX_MASK = 8'h3F;
  localparam logic [NFLAG-1:0] RST_VAL = 8'hC0;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_STAT_RD,
    ACC_DATA_RD,
    ACC_DATA_WR
  } acc_e;
endpackage

// File: rtl/uart_stat_decode.sv
module uart_stat_decode
  import uart_stat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd7
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              acc_o
);
  always_comb begin
    acc_o = ACC_NONE;
    if (valid_i) begin
      if (addr_i == DATA_ADDR) acc_o = write_i ? ACC_DATA_WR : ACC_DATA_RD;
      else if (addr_i == STAT_ADDR && !write_i) acc_o = ACC_STAT_RD;
    end
  end
endmodule

// File: rtl/uart_stat_cause.sv
module uart_stat_cause
  import uart_stat_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] tx_water_i,
  input  logic             tx_busy_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_water_i,
  input  logic             rx_idle_i,
  input  logic             rx_overrun_i,
  input  logic             rx_noise_i,
  input  logic             rx_frame_err_i,
  input  logic             rx_parity_err_i,
  output logic [NFLAG-1:0] set_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  always_comb begin
    set_o          = '0;
    set_o[B_TXE]   = (tx_count_i <= tx_water_i);
    set_o[B_TXC]   = (tx_count_i == CNT_ZERO) && !tx_busy_i;
    set_o[B_RXF]   = (rx_count_i != CNT_ZERO) && (rx_count_i >= rx_water_i);
    set_o[B_IDLE]  = rx_idle_i;
    set_o[B_OVR]   = rx_overrun_i;
    set_o[B_NOISE] = rx_noise_i;
    set_o[B_FRM]   = rx_frame_err_i;
    set_o[B_PAR]   = rx_parity_err_i;
  end
endmodule

// File: rtl/uart_stat_arm.sv
module uart_stat_arm
  import uart_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_e             acc_i,
  input  logic             flush_i,
  input  logic [NFLAG-1:0] flag_q_i,
  input  logic [NFLAG-1:0] flag_d_i,
  input  logic [NFLAG-1:0] dma_clr_i,
  output logic [NFLAG-1:0] sw_clr_o
);
  logic [NFLAG-1:0] armed_q, armed_d, kind_mask, arm_new, drop;

  always_comb begin
    unique case (acc_i)
      ACC_DATA_WR: kind_mask = TX_MASK;
      ACC_DATA_RD: kind_mask = RX_MASK;
      default:     kind_mask = '0;
    endcase
  end

  assign sw_clr_o = armed_q & kind_mask;
  assign arm_new  = (acc_i == ACC_STAT_RD) ? flag_q_i : '0;
  assign drop     = sw_clr_o | dma_clr_i | (flush_i ? RX_MASK : '0);
  // a flag that goes low for any reason loses its arm
  assign armed_d  = ((armed_q & ~drop) | arm_new) & flag_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= '0;
    else         armed_q <= armed_d;
  end

  // R5: status read arms every flag it sees, unless DMA strikes that cycle
  assert_status_read_arms_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_STAT_RD && dma_clr_i == '0) |=>
      (((armed_q | ~flag_q_i) & $past(flag_q_i)) == $past(flag_q_i)));
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
  import uart_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flag_q_o,
  output logic [NFLAG-1:0] flag_d_o
);
  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    // set wins over clear
    assign flag_d_o[k] = set_i[k] | (flag_q_o[k] & ~clr_i[k]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q_o[k] <= RST_VAL[k];
      else         flag_q_o[k] <= flag_d_o[k];
    end
  end

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_stat_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  tx_water_i,
  input  logic              tx_busy_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [CNT_W-1:0]  rx_water_i,
  input  logic              rx_idle_i,
  input  logic              rx_overrun_i,
  input  logic              rx_noise_i,
  input  logic              rx_frame_err_i,
  input  logic              rx_parity_err_i,
  input  logic              rx_flush_i,
  input  logic [7:0]        dma_sel_i,
  input  logic [7:0]        dma_done_i,
  input  logic [7:0]        irq_en_i,
  output logic [7:0]        status_o,
  output logic              irq_o,
  output logic [7:0]        dma_req_o,
  output logic              rx_pop_o,
  output logic              tx_push_o
);
  acc_e             acc;
  logic [NFLAG-1:0] set_v, sw_clr, dma_clr, flag_q, flag_d;

  uart_stat_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .valid_i(bus_valid_i), .write_i(bus_write_i), .addr_i(bus_addr_i), .acc_o(acc)
  );

  uart_stat_cause #(.CNT_W(CNT_W)) u_cause (
    .tx_count_i(tx_count_i), .tx_water_i(tx_water_i), .tx_busy_i(tx_busy_i),
    .rx_count_i(rx_count_i), .rx_water_i(rx_water_i),
    .rx_idle_i(rx_idle_i), .rx_overrun_i(rx_overrun_i), .rx_noise_i(rx_noise_i),
    .rx_frame_err_i(rx_frame_err_i), .rx_parity_err_i(rx_parity_err_i),
    .set_o(set_v)
  );

  assign dma_clr = dma_done_i & dma_sel_i;

  uart_stat_arm u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .flush_i(rx_flush_i),
    .flag_q_i(flag_q), .flag_d_i(flag_d), .dma_clr_i(dma_clr), .sw_clr_o(sw_clr)
  );

  uart_stat_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(sw_clr | dma_clr),
    .flag_q_o(flag_q), .flag_d_o(flag_d)
  );

  assign status_o  = flag_q;
  assign irq_o     = |(flag_q & irq_en_i & ~dma_sel_i);
  assign dma_req_o = flag_q & irq_en_i & dma_sel_i;
  // pops are never blocked, even from an empty FIFO
  assign rx_pop_o  = (acc == ACC_DATA_RD);
  assign tx_push_o = (acc == ACC_DATA_WR);

  // R6: a receive event flag only falls after a data read or a routed DMA-done
  assert_event_fall_needs_access_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_o[4:0]) & ~status_o[4:0]) != 5'd0) |->
      $past(rx_pop_o || (dma_clr != '0)));

  // R2: transmit-empty can only be low after a cycle above the watermark
  assert_txe_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[7]) |-> $past(tx_count_i > tx_water_i));
endmodule

// File: tb/uart_status_flags_bench.sv
`timescale 1ns/1ps
module uart_status_flags_bench;
  localparam logic [2:0] STAT = 3'd4;
  localparam logic [2:0] DATA = 3'd7;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [2:0] bus_addr = 0;
  logic [5:0] tx_count = 0, tx_water = 0, rx_count = 0, rx_water = 0;
  logic tx_busy = 0, ev_idle = 0, ev_ovr = 0, ev_noise = 0, ev_frm = 0, ev_par = 0, flush = 0;
  logic [7:0] dma_sel = 0, dma_done = 0, irq_en = 0;
  logic [7:0] status, dma_req;
  logic irq, pop, push;

  int checks = 0, errors = 0;
  logic [7:0] m_flag, m_arm;
  bit done = 0;

  always #2 clk = ~clk;

  uart_status_flags u_uart_status_flags (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .tx_count_i(tx_count), .tx_water_i(tx_water), .tx_busy_i(tx_busy),
    .rx_count_i(rx_count), .rx_water_i(rx_water), .rx_idle_i(ev_idle), .rx_overrun_i(ev_ovr),
    .rx_noise_i(ev_noise), .rx_frame_err_i(ev_frm), .rx_parity_err_i(ev_par),
    .rx_flush_i(flush), .dma_sel_i(dma_sel), .dma_done_i(dma_done), .irq_en_i(irq_en),
    .status_o(status), .irq_o(irq), .dma_req_o(dma_req), .rx_pop_o(pop), .tx_push_o(push)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Behavioural reference, one update per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= 8'hC0;
      m_arm  <= 8'h00;
    end else begin
      logic [7:0] nf, na;
      bit srd, drd, dwr, cause, kill;
      srd = bus_valid && !bus_write && bus_addr == STAT;
      drd = bus_valid && !bus_write && bus_addr == DATA;
      dwr = bus_valid && bus_write && bus_addr == DATA;
      for (int k = 0; k < 8; k++) begin
        case (k)
          7: cause = tx_count <= tx_water;
          6: cause = tx_count == 0 && !tx_busy;
          5: cause = rx_count != 0 && rx_count >= rx_water;
          4: cause = ev_idle;
          3: cause = ev_ovr;
          2: cause = ev_noise;
          1: cause = ev_frm;
          default: cause = ev_par;
        endcase
        kill = (m_arm[k] && (k >= 6 ? dwr : drd)) || (dma_done[k] && dma_sel[k]);
        nf[k] = cause || (m_flag[k] && !kill);
        na[k] = m_arm[k] && !kill && !(flush && k < 6);
        if (srd && m_flag[k]) na[k] = 1'b1;
        if (!nf[k]) na[k] = 1'b0;
      end
      m_flag <= nf;
      m_arm  <= na;
    end
  end

  function automatic string req_of(input int k);
    case (k)
      7: return "R2";
      6: return "R3";
      default: return "R4";
    endcase
  endfunction

  // per-cycle comparison, half a cycle from the edge
  always @(negedge clk) if (rst_n && !done) begin
    for (int k = 0; k < 8; k++)
      check(req_of(k), {7'd0, status[k]}, {7'd0, m_flag[k]});
    check("R9", {7'd0, irq}, {7'd0, |(m_flag & irq_en & ~dma_sel)});
    check("R9", dma_req, m_flag & irq_en & dma_sel);
    check("R10", {6'd0, pop, push},
          {6'd0, bus_valid && !bus_write && bus_addr == DATA, bus_valid && bus_write && bus_addr == DATA});
  end

  task automatic op();
    @(negedge clk); #1;
    bus_valid = 0; bus_write = 0; bus_addr = 0;
    {ev_idle, ev_ovr, ev_noise, ev_frm, ev_par, flush} = '0;
    dma_done = 0;
  endtask
  task automatic acc(input bit wr, input logic [2:0] a);
    op(); bus_valid = 1; bus_write = wr; bus_addr = a;
  endtask

  initial begin
    #(4.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #9 rst_n = 1;
    op();
    check("R1", status, 8'hC0);
    check("R1", {7'd0, irq}, 8'h00);
    check("R1", dma_req, 8'h00);

    // transmit side
    op(); tx_count = 3; tx_water = 2; tx_busy = 1;
    op();
    check("R6", status & 8'hC0, 8'hC0);        // level gone, no handshake yet
    acc(0, STAT); acc(1, DATA); op();
    check("R5", status & 8'hC0, 8'h00);
    op(); tx_count = 2; op();
    check("R2", status & 8'hC0, 8'h80);
    acc(0, STAT); acc(1, DATA); op();
    check("R7", status & 8'h80, 8'h80);        // still at watermark
    op(); tx_count = 0; op();
    check("R3", status & 8'h40, 8'h00);        // shifter still busy
    op(); tx_busy = 0; op();
    check("R3", status & 8'h40, 8'h40);

    // receive level flag
    op(); rx_water = 1; rx_count = 1; op();
    check("R4", status & 8'h20, 8'h20);
    acc(0, STAT); acc(1, DATA); op();
    check("R6", status & 8'h20, 8'h20);        // write is the wrong kind
    acc(1, 3'd0); acc(0, 3'd1); op(); rx_count = 0;
    acc(0, DATA); op();
    check("R5", status & 8'h20, 8'h00);

    // status read while flag low does not arm
    acc(0, STAT); op(); ev_par = 1; acc(0, DATA); op();
    check("R6", status & 8'h01, 8'h01);
    acc(0, STAT); acc(0, DATA); op();
    check("R5", status & 8'h01, 8'h00);

    // empty pop and flush
    op(); ev_frm = 1; acc(0, STAT); op(); flush = 1;
    acc(0, DATA); #1;
    check("R10", {7'd0, pop}, 8'h01);          // pop from empty FIFO
    op();
    check("R10", status & 8'h02, 8'h02);
    acc(0, STAT); acc(0, DATA); op();
    check("R10", status & 8'h02, 8'h00);

    // routing and DMA
    op(); ev_noise = 1; irq_en = 8'h04; op();
    check("R9", {7'd0, irq}, 8'h01);
    op(); dma_sel = 8'h04; #1;
    check("R9", {7'd0, irq}, 8'h00);
    check("R9", dma_req, 8'h04);
    op(); dma_sel = 8'h00; dma_done = 8'h04; op();
    check("R8", status & 8'h04, 8'h04);        // unrouted strobe ignored
    op(); dma_sel = 8'h04; acc(0, STAT); op(); dma_done = 8'h04; op();
    check("R8", status & 8'h04, 8'h00);
    op(); ev_noise = 1; acc(0, DATA); op();
    check("R8", status & 8'h04, 8'h04);        // arm was dropped with the flag
    op(); dma_done = 8'h04; op();
    dma_sel = 0; irq_en = 0;

    // set wins against clear
    op(); ev_idle = 1; acc(0, STAT); acc(0, DATA); ev_idle = 1; op();
    check("R7", status & 8'h10, 8'h10);
    op(); ev_ovr = 1; op();
    check("R4", status & 8'h08, 8'h08);
    acc(0, STAT); acc(0, DATA); op();
    check("R5", status & 8'h18, 8'h00);

    op(); op();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule